// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands of `W` bits (8 by default) and yields a `2*W`-bit product. It trades speed for area. It holds a single adder of `W+1` bits and one accumulator of double width, and it needs `W` clock cycles per product. In each cycle it looks at the lowest bit of the remaining multiplier. When that bit is 1, it adds the multiplicand into the upper half of the accumulator. It then shifts the whole accumulator right by one place, and the adder carry enters at the top.

The surrounding logic drives `go` while `ready` is high. The unit captures both operands on that clock edge, so the operand inputs may change on the very next cycle. When the product is complete, the unit raises `done`, and `prod` holds the result for as long as the unit stays in that state. The done state also counts as ready, so a new operation can start on any cycle after the result appears. A low level on the synchronous active-low reset aborts any run in progress.

Top module: `shiftadd_mul`

## Requirements
- R1: On any clock edge where `rst_n` is low, the unit enters idle. After that edge, `ready` is 1 and `done` is 0.
- R2: When `go` is high at an edge and the unit is idle, the operation is accepted. After that edge, `ready` and `done` are both 0.
- R3: `done` first reads 1 exactly `W` clock edges after the accepting edge. Before that, `ready` and `done` stay 0.
- R4: While `done` is 1, `prod` equals the full `2*W`-bit unsigned product of the two operands captured at the accepting edge. This includes the extremes 0 and `(2^W-1)*(2^W-1)`.
- R5: Changes on `mcand_in` and `mplier_in` after the accepting edge have no effect on the product.
- R6: `go` is ignored while an operation is running. Holding it high neither restarts the run nor changes the latency or the result.
- R7: A low `rst_n` during a run aborts it. The unit is then idle and ready, and the next accepted operation produces a correct product.
- R8: In the done state, `ready` and `done` are both 1. While `go` stays low, the unit stays done and `prod` does not change.
- R9: When `go` is high at an edge in the done state, a new operation is accepted with the new operands. After that edge, `done` and `ready` are 0.
- R10: While idle with `go` low, the unit stays idle. `ready` stays 1 and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low; aborts any run |
| go | input | 1 | Start request, accepted only while `ready` is 1 |
| mcand_in | input | W | Unsigned multiplicand, captured at acceptance |
| mplier_in | input | W | Unsigned multiplier, captured at acceptance |
| ready | output | 1 | Unit is idle or done and will accept `go` |
| prod | output | 2*W | Product; valid while `done` is 1 |
| done | output | 1 | Unit is in the done state |

## Verification
The operand pairs cover zero against zero and against all-ones, all-ones squared, a single set bit on either side, the top bit squared, and alternating bit patterns. These expose a lost top carry, a shift that runs one step too many or too few, and a skipped low or high bit. Pseudo-random pairs are added on top of them. Some runs scramble the operand inputs every cycle, and others hold `go` high through the whole run. These separate a unit that latches its operands from one that reads its inputs live, and an ignored start from a restart. Runs are also cut by reset at early, middle and final steps, and some operations start again straight from the done state. A cycle-level model checks the latency, the handshake levels and the result on every clock.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_e;

    typedef struct packed {
        logic load;
        logic step;
    } mul_ctl_t;

    function automatic int unsigned cnt_width(input int unsigned steps);
        return (steps > 1) ? $clog2(steps) : 1;
    endfunction

endpackage

// File: rtl/shiftadd_mul_ctrl.sv
module shiftadd_mul_ctrl
    import shiftadd_mul_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     go,
    output mul_ctl_t ctl,
    output logic     ready,
    output logic     done
);
    localparam int unsigned CW = cnt_width(W);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    mul_state_e      st_q;
    logic [CW-1:0]   step_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            step_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_DONE: begin
                    if (go) begin
                        st_q   <= ST_RUN;
                        step_q <= '0;
                    end
                end
                ST_RUN: begin
                    step_q <= step_q + 1'b1;
                    if (step_q == LAST_STEP) begin
                        st_q <= ST_DONE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.load = go && (st_q != ST_RUN);
        ctl.step = (st_q == ST_RUN);
        ready    = (st_q != ST_RUN);
        done     = (st_q == ST_DONE);
    end

endmodule

// File: rtl/shiftadd_mul_dp.sv
module shiftadd_mul_dp
    import shiftadd_mul_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  mul_ctl_t       ctl,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] prod
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] acc_q;
    logic [W-1:0]  mcand_q;
    logic [W-1:0]  addend;
    logic [W:0]    upper_sum;
    logic [PW-1:0] acc_nxt;

    always_comb begin
        addend    = acc_q[0] ? mcand_q : '0;
        upper_sum = {1'b0, acc_q[PW-1:W]} + {1'b0, addend};
        acc_nxt   = {upper_sum, acc_q[W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mcand_q <= '0;
        end else if (ctl.load) begin
            acc_q   <= {{W{1'b0}}, mplier_in};
            mcand_q <= mcand_in;
        end else if (ctl.step) begin
            acc_q   <= acc_nxt;
        end
    end

    assign prod = acc_q;

endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
    import shiftadd_mul_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic           ready,
    output logic [2*W-1:0] prod,
    output logic           done
);
    mul_ctl_t ctl;

    shiftadd_mul_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .ctl   (ctl),
        .ready (ready),
        .done  (done)
    );

    shiftadd_mul_dp #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mcand_in  (mcand_in),
        .mplier_in (mplier_in),
        .prod      (prod)
    );

endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk #(
    parameter int unsigned W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           go,
    input logic [W-1:0]   mcand_in,
    input logic [W-1:0]   mplier_in,
    input logic           ready,
    input logic [2*W-1:0] prod,
    input logic           done
);
    localparam int unsigned KW = $clog2(W + 2) + 1;

    logic           rst_seen_q = 1'b0;
    logic           busy_q;
    logic [KW-1:0]  cyc_q;
    logic [2*W-1:0] exp_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
        if (!rst_n) begin
            busy_q <= 1'b0;
            cyc_q  <= '0;
            exp_q  <= '0;
        end else if (go && ready) begin
            busy_q <= 1'b1;
            cyc_q  <= '0;
            exp_q  <= {{W{1'b0}}, mcand_in} * {{W{1'b0}}, mplier_in};
        end else if (busy_q && done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cyc_q  <= cyc_q + 1'b1;
        end
    end

    always @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_idle_R1: assert (ready && !done);
        end
    end

    assert_accept_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && ready && !done) |=> (!ready && !done));

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && done) |-> (cyc_q == KW'(W)));

    assert_product_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && done) |-> (prod == exp_q));

    assert_run_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready) |=> (ready == done));

    assert_done_is_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !go) |=> (done && $stable(prod)));

    assert_restart_from_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && go) |=> (!done && !ready));

    assert_idle_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !done && !go) |=> (ready && !done));

endmodule

bind shiftadd_mul shiftadd_mul_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .mcand_in  (mcand_in),
    .mplier_in (mplier_in),
    .ready     (ready),
    .prod      (prod),
    .done      (done)
);

// File: tb/shiftadd_mul_bench.sv
`timescale 1ns/1ps
module shiftadd_mul_bench;
    localparam int unsigned W  = 8;
    localparam int unsigned PW = 2 * W;
    localparam int unsigned WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic [W-1:0]  mcand_in = '0;
    logic [W-1:0]  mplier_in = '0;
    logic          ready;
    logic [PW-1:0] prod;
    logic          done;

    shiftadd_mul #(.W(W)) u_shiftadd_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .mcand_in  (mcand_in),
        .mplier_in (mplier_in),
        .ready     (ready),
        .prod      (prod),
        .done      (done)
    );

    always #2.5 clk = ~clk;

    int          n_checks = 0;
    int          n_fails  = 0;
    int          n_cycles = 0;
    string       cur_tag  = "R1";
    int unsigned rng      = 32'h1234_5678;

    // behavioural model: 0 idle, 1 running, 2 done
    int            m_st   = 0;
    int            m_left = 0;
    logic [PW-1:0] m_exp  = '0;
    bit            m_live = 1'b0;

    function automatic logic [W-1:0] next_rand();
        rng = rng * 32'd1664525 + 32'd1013904223;
        return rng[23:16];
    endfunction

    task automatic check_eq(input string tag, input string what,
                            input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cycles++;
        if (!rst_n) begin
            m_st   = 0;
            m_live = 1'b1;
        end else if (m_st == 1) begin
            m_left = m_left - 1;
            if (m_left == 0) m_st = 2;
        end else if (go) begin
            m_st   = 1;
            m_left = W;
            m_exp  = {{W{1'b0}}, mcand_in} * {{W{1'b0}}, mplier_in};
        end
        #1;
        if (m_live) begin
            check_eq(cur_tag, "ready", PW'(ready), PW'(m_st != 1));
            check_eq(cur_tag, "done",  PW'(done),  PW'(m_st == 2));
            if (m_st == 2) check_eq(cur_tag, "prod", prod, m_exp);
        end
        if (n_cycles > WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", n_cycles, WATCHDOG);
            summary();
        end
    end

    task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit scramble, input bit hold_go, input int dwell);
        int n;
        @(negedge clk);
        mcand_in  = a;
        mplier_in = b;
        go        = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) go = hold_go;
            if (scramble) begin
                mcand_in  = next_rand();
                mplier_in = next_rand();
            end
        end while (!done && n < 4 * W);
        go = 1'b0;
        // R3: done is visible at the negedge following the W-th run edge
        check_eq("R3", "latency", PW'(n), PW'(W + 1));
        check_eq("R4", "product", prod, {{W{1'b0}}, a} * {{W{1'b0}}, b});
        mcand_in  = next_rand();
        mplier_in = next_rand();
        repeat (dwell) @(negedge clk);
    endtask

    task automatic abort_op(input logic [W-1:0] a, input logic [W-1:0] b, input int k);
        @(negedge clk);
        mcand_in  = a;
        mplier_in = b;
        go        = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (k) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_eq("R7", "ready after abort", PW'(ready), PW'(1));
        check_eq("R7", "done after abort",  PW'(done),  PW'(0));
    endtask

    initial begin
        cur_tag = "R1";
        repeat (3) @(negedge clk);
        check_eq("R1", "ready in reset", PW'(ready), PW'(1));
        check_eq("R1", "done in reset",  PW'(done),  PW'(0));
        rst_n = 1'b1;

        cur_tag = "R10";
        mcand_in = 8'h3C; mplier_in = 8'h5A;
        repeat (6) @(negedge clk);
        check_eq("R10", "idle ready", PW'(ready), PW'(1));
        check_eq("R10", "idle done",  PW'(done),  PW'(0));

        cur_tag = "R2";
        @(negedge clk);
        mcand_in = 8'h07; mplier_in = 8'h09; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check_eq("R2", "ready after accept", PW'(ready), PW'(0));
        check_eq("R2", "done after accept",  PW'(done),  PW'(0));
        repeat (W + 1) @(negedge clk);

        cur_tag = "R4";
        do_op(8'h00, 8'h00, 0, 0, 1);
        do_op(8'h00, 8'hFF, 0, 0, 1);
        do_op(8'hFF, 8'h00, 0, 0, 1);
        do_op(8'hFF, 8'hFF, 0, 0, 1);
        do_op(8'h01, 8'hFF, 0, 0, 1);
        do_op(8'hFF, 8'h01, 0, 0, 1);
        do_op(8'h80, 8'h80, 0, 0, 1);
        do_op(8'hAA, 8'h55, 0, 0, 1);
        do_op(8'h55, 8'hAA, 0, 0, 1);
        for (int i = 0; i < 24; i++) begin
            logic [W-1:0] ra, rb;
            ra = next_rand();
            rb = next_rand();
            do_op(ra, rb, 0, 0, i % 3);
        end

        cur_tag = "R5";
        do_op(8'hFF, 8'hFF, 1, 0, 1);
        do_op(8'h81, 8'h7E, 1, 0, 1);
        do_op(8'h00, 8'h13, 1, 0, 1);

        cur_tag = "R6";
        do_op(8'hC3, 8'h3C, 0, 1, 1);
        do_op(8'hFF, 8'hFE, 1, 1, 1);

        cur_tag = "R8";
        do_op(8'h9D, 8'hE7, 0, 0, 8);
        check_eq("R8", "ready in done", PW'(ready), PW'(1));
        check_eq("R8", "done held",     PW'(done),  PW'(1));
        check_eq("R8", "product held",  prod, 16'h9D * 16'hE7);

        cur_tag = "R9";
        do_op(8'h12, 8'h34, 0, 0, 0);
        do_op(8'hFE, 8'hFD, 0, 0, 0);
        do_op(8'h01, 8'h01, 0, 0, 1);

        cur_tag = "R7";
        abort_op(8'hFF, 8'hFF, 0);
        abort_op(8'hA5, 8'h5A, 3);
        abort_op(8'h77, 8'h99, W - 2);
        do_op(8'hFF, 8'hFF, 0, 0, 1);
        abort_op(8'h11, 8'h22, W / 2);
        do_op(8'h0F, 8'hF0, 0, 0, 2);

        summary();
    end

endmodule